// File: doc/BRIEF.md
# Fast Page Mode DRAM Access Sequencer

This block is a synchronous controller for an asynchronous DRAM. The DRAM shares its address pins between the row and the column, and it has an 8-bit data path. A host hands the block one word access at a time over a valid/ready port, using a flat word address. The block splits that address into a row and a column. It drives the row and column strobes, the write strobe, the output-enable strobe and the shared address pins. It also returns read data with a single-cycle valid pulse.

After an access, the row stays open. A later request to the same row is served with a new column strobe only, so the row activate and precharge are skipped. The open row is closed in three cases: the next request targets another row, an external refresh request is raised, or the row has been held long enough to approach the maximum strobe-low time. Every analog timing minimum is a clock count set by a parameter, so one RTL serves any clock rate. All writes are early writes: the write strobe and the write data are set up before the column strobe falls.

Top module: `fpm_seq`

## Requirements
- R1: While reset is held and on release, the row, column, write and output-enable strobes are high, the data drive enable is low and `rd_valid` is low.
- R2: The row is `req_addr[18:9]` and is presented on `dram_addr` when the row strobe falls. The column is `req_addr[8:0]` and is presented on `dram_addr[8:0]` with `dram_addr[9]` low when the column strobe falls.
- R3: A request to the row that is already open is served by a column strobe alone, and the row strobe stays low between the accesses.
- R4: A request to a different row raises the row strobe, keeps it high for at least `T_RP` cycles, and then activates the new row.
- R5: After a row activate, the first column strobe falls exactly `T_RCD` cycles after the row strobe fell.
- R6: Each column strobe stays low for exactly `T_CAS` cycles. Inside an open row, the column strobe is high for at least `T_CP` cycles between two low pulses.
- R7: Each row-strobe low period lasts at least `T_RAS_MIN` and at most `T_RAS_MAX` cycles. An open row with no further accepted request closes by itself within that limit.
- R8: For a write, the write strobe is low and the data drive enable is high (with `req_wdata` on `dram_dq_out`) at least one cycle before the column strobe falls. Output enable stays high for the whole write.
- R9: For a read, output enable is low while the column strobe is low. `dram_dq_in` is captured `T_RDLAT` cycles after the column strobe fell, and it is returned on `rd_data` with `rd_valid` high for exactly one cycle.
- R10: While `refresh_req` is high, `req_ready` is low and no request is accepted. Once any open row has been closed, the row strobe stays high.
- R11: `req_ready` is high only in two cases: the sequencer is idle after precharge, or a row is open, the requested row matches it, and the row still has time left before its limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address, row in the upper 10 bits |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Read data |
| refresh_req | input | 1 | External refresh pending, forces the row closed |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the data driver |
| dram_dq_in | input | 8 | Data read from the DRAM |

## Verification
All strobes are registered, so each edge is counted in clock edges from the edge that caused it. The first column strobe falls `T_RCD` edges after the row strobe. The column strobe rises `T_CAS` edges after it fell. Read data is valid `T_RDLAT` edges after the column fall. The row strobe rises no later than `T_RAS_MAX` edges after it fell. The bench samples every output at the falling clock edge, stamps each strobe transition with the count of rising edges seen so far, and compares the differences of those stamps against the parameters rather than waiting a fixed time. A DRAM model in the bench latches the row and column at the strobe falls and answers reads. A scoreboard pairs each accepted read with its returned word.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_CPRE,
        ST_OPEN,
        ST_PRE
    } fpm_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_row_match.sv
module fpm_row_match #(
    parameter int ROW_W = 10,
    parameter int COL_W = 9
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [ROW_W-1:0]       open_row,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic                   hit
);
    assign row = addr[ROW_W+COL_W-1:COL_W];
    assign col = addr[COL_W-1:0];
    assign hit = (row == open_row);
endmodule

// File: rtl/fpm_ras_age.sv
module fpm_ras_age #(
    parameter int T_RAS_MIN = 3,
    parameter int T_RAS_MAX = 500,
    parameter int HIT_LIMIT = 495
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic min_ok,
    output logic stale
);
    localparam int AW = $clog2(T_RAS_MAX + 2);

    logic [AW-1:0] age_d, age_q;

    always_comb begin
        if (!ras_low)
            age_d = '0;
        else if (age_q == AW'(T_RAS_MAX))
            age_d = age_q;
        else
            age_d = age_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // age_q counts low cycles already completed before the current edge
    assign min_ok = (int'(age_q) + 1 >= T_RAS_MIN);
    assign stale  = (int'(age_q) > HIT_LIMIT);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 9,
    parameter int DQ_W      = 8,
    parameter int T_RP      = 2,
    parameter int T_RCD     = 1,
    parameter int T_CAS     = 1,
    parameter int T_RDLAT   = 1,
    parameter int T_CP      = 1,
    parameter int T_RAS_MIN = 3,
    parameter int T_RAS_MAX = 500
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    output logic                   rd_valid,
    output logic [DQ_W-1:0]        rd_data,
    input  logic                   refresh_req,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_in
);
    localparam int TMAX      = max_of(max_of(T_RP, T_RCD), max_of(T_CAS, T_CP));
    localparam int TW        = $clog2(TMAX + 1);
    localparam int HIT_LIMIT = T_RAS_MAX - T_CAS - T_CP - 3;
    localparam int RD_TAP    = T_CAS - T_RDLAT;

    typedef struct packed {
        fpm_state_e       st;
        logic [TW-1:0]    tmr;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             we;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe_n;
        logic             dq_oe;
        logic [DQ_W-1:0]  wdata;
        logic [ROW_W-1:0] addr;
        logic             rd_valid;
        logic [DQ_W-1:0]  rd_data;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [ROW_W-1:0] row_in;
    logic [COL_W-1:0] col_in;
    logic             hit, min_ok, stale;
    logic             take_idle, take_hit, want_close;

    fpm_row_match #(.ROW_W(ROW_W), .COL_W(COL_W)) u_match (
        .addr     (req_addr),
        .open_row (q.row),
        .row      (row_in),
        .col      (col_in),
        .hit      (hit)
    );

    fpm_ras_age #(
        .T_RAS_MIN (T_RAS_MIN),
        .T_RAS_MAX (T_RAS_MAX),
        .HIT_LIMIT (HIT_LIMIT)
    ) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_low (!q.ras_n),
        .min_ok  (min_ok),
        .stale   (stale)
    );

    assign take_idle  = (q.st == ST_IDLE) && !refresh_req;
    assign take_hit   = (q.st == ST_OPEN) && !refresh_req && hit && !stale;
    assign req_ready  = take_idle || take_hit;
    assign want_close = refresh_req || stale || (req_valid && !hit);

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid && take_idle) begin
                    d.st    = ST_ACT;
                    d.tmr   = TW'(T_RCD - 1);
                    d.ras_n = 1'b0;
                    d.addr  = row_in;
                    d.row   = row_in;
                    d.col   = col_in;
                    d.we    = req_we;
                    d.wdata = req_wdata;
                    d.we_n  = !req_we;
                    d.dq_oe = req_we;
                end
            end
            ST_ACT: begin
                if (q.tmr == '0) begin
                    d.st    = ST_COL;
                    d.tmr   = TW'(T_CAS - 1);
                    d.cas_n = 1'b0;
                    d.oe_n  = q.we;
                    d.addr  = ROW_W'(q.col);
                end else begin
                    d.tmr = q.tmr - TW'(1);
                end
            end
            ST_COL: begin
                if (!q.we && q.tmr == TW'(RD_TAP)) begin
                    d.rd_valid = 1'b1;
                    d.rd_data  = dram_dq_in;
                end
                if (q.tmr == '0) begin
                    d.st    = ST_CPRE;
                    d.tmr   = TW'(T_CP - 1);
                    d.cas_n = 1'b1;
                    d.oe_n  = 1'b1;
                    d.we_n  = 1'b1;
                    d.dq_oe = 1'b0;
                end else begin
                    d.tmr = q.tmr - TW'(1);
                end
            end
            ST_CPRE: begin
                if (q.tmr == '0) d.st  = ST_OPEN;
                else             d.tmr = q.tmr - TW'(1);
            end
            ST_OPEN: begin
                if (req_valid && take_hit) begin
                    d.st    = ST_ACT;
                    d.tmr   = '0;
                    d.col   = col_in;
                    d.we    = req_we;
                    d.wdata = req_wdata;
                    d.we_n  = !req_we;
                    d.dq_oe = req_we;
                    d.addr  = ROW_W'(col_in);
                end else if (want_close && min_ok) begin
                    d.st    = ST_PRE;
                    d.tmr   = TW'(T_RP - 1);
                    d.ras_n = 1'b1;
                end
            end
            ST_PRE: begin
                if (q.tmr == '0) d.st  = ST_IDLE;
                else             d.tmr = q.tmr - TW'(1);
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_valid    = q.rd_valid;
    assign rd_data     = q.rd_data;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_addr   = q.addr;
    assign dram_dq_out = q.wdata;
    assign dram_dq_oe  = q.dq_oe;
endmodule

// File: rtl/fpm_seq_chk.sv
module fpm_seq_chk #(
    parameter int T_RP      = 2,
    parameter int T_RCD     = 1,
    parameter int T_CAS     = 1,
    parameter int T_CP      = 1,
    parameter int T_RAS_MIN = 3,
    parameter int T_RAS_MAX = 500
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic rd_valid,
    input logic refresh_req,
    input logic req_ready
);
    localparam int unsigned SAT = 32'h000F_FFFF;

    int unsigned ras_lo, ras_hi, cas_lo, cas_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo <= 0;
            ras_hi <= T_RP;
            cas_lo <= 0;
            cas_hi <= T_CP;
        end else begin
            ras_lo <= ras_n  ? 0 : ((ras_lo < SAT) ? ras_lo + 1 : ras_lo);
            ras_hi <= !ras_n ? 0 : ((ras_hi < SAT) ? ras_hi + 1 : ras_hi);
            cas_lo <= cas_n  ? 0 : ((cas_lo < SAT) ? cas_lo + 1 : cas_lo);
            cas_hi <= !cas_n ? 0 : ((cas_hi < SAT) ? cas_hi + 1 : cas_hi);
        end
    end

    // R4
    ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ras_hi >= T_RP);

    // R5
    ras_to_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (!ras_n && ras_lo >= T_RCD));

    // R6
    cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> cas_lo == T_CAS);

    // R6
    cas_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> cas_hi >= T_CP);

    // R7
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> ras_lo < T_RAS_MAX);

    // R7
    ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ras_lo >= T_RAS_MIN);

    // R8
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> ($past(!we_n) && dq_oe && oe_n));

    // R8
    no_drive_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    // R9
    read_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && we_n) |-> !oe_n);

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R10
    refresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && ras_n) |=> ras_n);

    // R10
    refresh_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> !req_ready);
endmodule

bind fpm_seq fpm_seq_chk #(
    .T_RP      (T_RP),
    .T_RCD     (T_RCD),
    .T_CAS     (T_CAS),
    .T_CP      (T_CP),
    .T_RAS_MIN (T_RAS_MIN),
    .T_RAS_MAX (T_RAS_MAX)
) u_fpm_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .oe_n        (dram_oe_n),
    .dq_oe       (dram_dq_oe),
    .rd_valid    (rd_valid),
    .refresh_req (refresh_req),
    .req_ready   (req_ready)
);

// File: tb/fpm_seq_bench.sv
module fpm_seq_bench;
    localparam int ROW_W     = 10;
    localparam int COL_W     = 9;
    localparam int T_RP      = 3;
    localparam int T_RCD     = 2;
    localparam int T_CAS     = 3;
    localparam int T_RDLAT   = 2;
    localparam int T_CP      = 1;
    localparam int T_RAS_MIN = 10;
    localparam int T_RAS_MAX = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, refresh_req = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, dq_in_r = '0;
    logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [7:0] rd_data, dq_out;
    logic [9:0] daddr;

    always #10 clk = ~clk;

    fpm_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(8),
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RDLAT(T_RDLAT),
        .T_CP(T_CP), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX)
    ) u_fpm_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .refresh_req(refresh_req),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(daddr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in_r)
    );

    int total = 0, bad = 0, cyc = 0, ras_falls = 0;
    logic [18:0] acc_q[$];
    logic [7:0]  exp_q[$];
    logic [7:0]  ref_mem[int];
    logic [7:0]  dram_mem[int];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: one request, waits for ready, records expectations
    task automatic issue(input logic we, input logic [18:0] a, input logic [7:0] dat);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = dat;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        acc_q.push_back(a);
        if (we) ref_mem[int'(a)] = dat;
        else    exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
        #1 req_valid = 1'b0;
    endtask

    // DRAM model and protocol monitor
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, prev_rv = 1'b0, first_cas = 1'b0;
    int ras_fall_c = 0, ras_rise_c = -1000, cas_fall_c = 0, cas_rise_c = 0;
    logic [9:0] m_row = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                check(cyc - ras_rise_c >= T_RP, "R4 ras high time", cyc - ras_rise_c, T_RP);
                ras_fall_c = cyc; m_row = daddr; first_cas = 1'b1; ras_falls++;
            end
            if (!prev_ras && ras_n) begin
                check(cyc - ras_fall_c >= T_RAS_MIN, "R7 ras low min", cyc - ras_fall_c, T_RAS_MIN);
                check(cyc - ras_fall_c <= T_RAS_MAX, "R7 ras low max", cyc - ras_fall_c, T_RAS_MAX);
                ras_rise_c = cyc;
            end
            if (prev_cas && !cas_n) begin
                logic [8:0]  mcol;
                logic [18:0] ea;
                mcol = daddr[8:0];
                if (first_cas)
                    check(cyc - ras_fall_c == T_RCD, "R5 ras-to-cas", cyc - ras_fall_c, T_RCD);
                else
                    check(cyc - cas_rise_c >= T_CP, "R6 cas precharge", cyc - cas_rise_c, T_CP);
                first_cas = 1'b0;
                check(daddr[9] == 1'b0, "R2 column top pin", int'(daddr[9]), 0);
                ea = (acc_q.size() > 0) ? acc_q.pop_front() : 19'h0;
                check({m_row, mcol} == ea, "R2 R3 row/column mux", int'({m_row, mcol}), int'(ea));
                if (!we_n) begin
                    check(!prev_we && dq_oe && oe_n, "R8 early write setup",
                          int'({prev_we, dq_oe, oe_n}), 3'b011);
                    dram_mem[int'({m_row, mcol})] = dq_out;
                    dq_in_r = 8'h00;
                end else begin
                    check(!oe_n, "R9 output enable on read", int'(oe_n), 0);
                    dq_in_r = dram_mem.exists(int'({m_row, mcol})) ? dram_mem[int'({m_row, mcol})] : 8'h00;
                end
                cas_fall_c = cyc;
            end
            if (!prev_cas && cas_n) begin
                check(cyc - cas_fall_c == T_CAS, "R6 cas width", cyc - cas_fall_c, T_CAS);
                cas_rise_c = cyc;
            end
            if (rd_valid) begin
                logic [7:0] e;
                check(cyc - cas_fall_c == T_RDLAT, "R9 read latency", cyc - cas_fall_c, T_RDLAT);
                check(!prev_rv, "R9 single-cycle valid", int'(prev_rv), 0);
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                check(rd_data === e, "R9 read data", int'(rd_data), int'(e));
            end
            prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n; prev_rv = rd_valid;
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int f0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid, "R1 reset outputs",
              int'({ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid}), 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        check(ras_n && cas_n && !rd_valid, "R1 after release", int'({ras_n, cas_n, rd_valid}), 3'b110);

        // R3: four writes to one row, one activate
        f0 = ras_falls;
        for (int i = 0; i < 4; i++) issue(1'b1, {10'd5, 9'(i)}, 8'(8'hA0 + i));
        repeat (8) @(negedge clk);
        check(ras_falls - f0 == 1, "R3 page hit activates once", ras_falls - f0, 1);
        for (int i = 0; i < 4; i++) issue(1'b0, {10'd5, 9'(i)}, 8'h00);

        // R4: alternate rows
        repeat (5) @(negedge clk);
        f0 = ras_falls;
        issue(1'b1, {10'd9, 9'd7}, 8'h5C);
        issue(1'b0, {10'd5, 9'd1}, 8'h00);
        repeat (12) @(negedge clk);
        check(ras_falls - f0 == 2, "R4 row miss reactivates", ras_falls - f0, 2);

        // R10: refresh closes and blocks
        issue(1'b0, {10'd9, 9'd7}, 8'h00);
        refresh_req = 1'b1;
        req_valid = 1'b1; req_we = 1'b0; req_addr = {10'd9, 9'd7};
        repeat (45) @(negedge clk);
        check(ras_n == 1'b1, "R10 row closed during refresh", int'(ras_n), 1);
        check(req_ready == 1'b0, "R10 no ready during refresh", int'(req_ready), 0);
        check(acc_q.size() == 0, "R10 nothing accepted", acc_q.size(), 0);
        req_valid = 1'b0; refresh_req = 1'b0;

        // R7: idle open row closes by itself
        issue(1'b0, {10'd9, 9'd7}, 8'h00);
        repeat (T_RAS_MAX + 6) @(negedge clk);
        check(ras_n == 1'b1, "R7 idle row auto close", int'(ras_n), 1);

        // R7: long run of hits must be split
        f0 = ras_falls;
        for (int i = 0; i < 12; i++) issue(1'b0, {10'd5, 9'(i % 4)}, 8'h00);
        repeat (12) @(negedge clk);
        check(ras_falls - f0 >= 2, "R7 long page split", ras_falls - f0, 2);

        // R2: address extremes
        issue(1'b1, 19'h7FFFF, 8'hE7);
        issue(1'b1, 19'h00000, 8'h3D);
        issue(1'b1, 19'h7FE00, 8'h81);
        issue(1'b0, 19'h7FFFF, 8'h00);
        issue(1'b0, 19'h00000, 8'h00);
        issue(1'b0, 19'h7FE00, 8'h00);

        // R11: ready low while mid-access
        issue(1'b0, {10'd3, 9'd3}, 8'h00);
        @(negedge clk); #1;
        check(req_ready == 1'b0, "R11 no ready during column cycle", int'(req_ready), 0);

        repeat (60) @(negedge clk);
        check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
        finish_run();
    end
endmodule